// File: doc/BRIEF.md
# Operand Interlock Unit

This block decides, cycle by cycle, whether the instruction sitting in the second issue stage (I2) of a six-stage issue/execute pipeline (I1, I2, E1, E2, E3, E4) may leave that stage. It keeps a short record of recently issued destination registers. Each record notes whether the producer's result becomes ready at E2 (arithmetic, shifts, SIMD, multiply, multiply-accumulate, divide, link address, base-update address) or at E3 (loads). Each source operand of the waiting instruction is tagged with the stage at which it needs its value: the early stage E1 or the late stage E2. The unit works out how many more cycles must pass before every operand can be forwarded, and reports that number together with a stall flag.

Load-multiple instructions are split into one micro-operation per word, and these issue on consecutive cycles. The unit sequences them itself. While a load-multiple is still issuing its later words, it holds the issue handshake closed. It treats every word as an independent load issued in its own slot, so a consumer of the final word waits longer than a consumer of an earlier word. A pipeline flush discards all records at once.

The issue side is a valid/ready handshake. The issuer raises `iss_valid` with the instruction's fields. The instruction is accepted on a rising clock edge where both `iss_valid` and `iss_ready` are high. While `iss_valid` is high and `iss_ready` is low, the issuer must hold every issue field stable. The back-pressure never depends on `iss_valid`. `flush` is a plain control input.

Top module: `opnd_interlock`

## Requirements
- R1: After reset there are no records and no load-multiple in progress: `stall_cycles` is 0 and `iss_ready` is 1. `iss_ready` is 1 exactly when `stall_cycles` is 0 and `flush` is low. `stall` equals `iss_valid` and (`stall_cycles` != 0). An instruction issues on a clock edge where both `iss_valid` and `iss_ready` are high.
- R2: For a producer of kind execute (`dst_kind` 01, ready at E2), the required issue separation is 2 cycles to an early consumer and 1 cycle (back-to-back, no stall) to a late consumer.
- R3: For a producer of kind load (`dst_kind` 10, ready at E3), the required separation is 3 cycles to an early consumer and 2 cycles to a late consumer.
- R4: `stall_cycles` equals the required separation minus the cycles elapsed since the producer issued, floored at 0. While the waiting instruction's sources are held and no flush occurs, it falls by exactly one per cycle.
- R5: `src_need` uses 2 bits per operand: 01 means needed at E1, 10 means needed at E2, and 00 or 11 means the operand is unused. An unused operand never causes a stall. A shift-then-ALU instruction's shifted operand is marked 01.
- R6: A source register 0 never causes a stall. A producer with `dst_kind` 00, or with a destination register 0, leaves no record.
- R7: When several operands or several older producers match, `stall_cycles` is the largest of the individual remaining counts.
- R8: A load-multiple (`dst_kind` 11) of N words writes word m (1-based) to register `dst_reg`+m−1, wrapping modulo the register count. Word m is treated as a load issued m−1 cycles after the instruction.
- R9: After a load-multiple of N words issues, `iss_ready` stays low for the next N−1 cycles. During those cycles `stall_cycles` reports the full remaining wait, including the words not yet issued. A `lmw_words` value of 0 is treated as 1.
- R10: While `flush` is high nothing issues. In the following cycle all records and any unfinished load-multiple are gone, so `stall_cycles` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Pipeline flush; discards all records |
| iss_valid | input | 1 | An instruction is present in I2 |
| iss_ready | output | 1 | The instruction in I2 may issue this cycle |
| src_reg | input | NSRC*RW | Source register numbers; operand s occupies bits [RW*s +: RW] |
| src_need | input | 2*NSRC | Per-operand need stage; operand s occupies bits [2*s +: 2] |
| dst_reg | input | RW | Destination register (first word for load-multiple) |
| dst_kind | input | 2 | 00 none, 01 execute, 10 load, 11 load-multiple |
| lmw_words | input | CW | Word count for load-multiple |
| stall | output | 1 | The presented instruction is held this cycle |
| stall_cycles | output | SCW | Cycles still to wait before the presented instruction can issue |

## Verification
A stale or misaged record appears at the ports when a consumer is first presented. It shows as a `stall_cycles` value that is off by one or more, and then as an `iss_ready` that rises a cycle early or late. A lost record lets a dependent instruction issue back-to-back immediately. A sequencer that miscounts load-multiple words shifts the cycle in which `iss_ready` returns, or stalls a consumer of the wrong word. Sweeping producer kind, need stage, word index and gap exposes each of these within a few cycles of the producer's issue.

// File: rtl/opnd_interlock_pkg.sv
package opnd_interlock_pkg;

  typedef enum logic [1:0] {
    PK_NONE   = 2'b00,
    PK_EXEC   = 2'b01,
    PK_LOAD   = 2'b10,
    PK_LMULTI = 2'b11
  } prod_kind_e;

  typedef enum logic [1:0] {
    NEED_NONE  = 2'b00,
    NEED_EARLY = 2'b01,
    NEED_LATE  = 2'b10,
    NEED_RSVD  = 2'b11
  } need_e;

  // issue separation in cycles, indexed by producer ready stage and consumer need stage
  localparam int LAT_EX_EARLY = 2;
  localparam int LAT_EX_LATE  = 1;
  localparam int LAT_LD_EARLY = 3;
  localparam int LAT_LD_LATE  = 2;
  localparam int LAT_MAX      = LAT_LD_EARLY;

  function automatic int req_lat(input logic from_load, input logic early);
    if (from_load) return early ? LAT_LD_EARLY : LAT_LD_LATE;
    return early ? LAT_EX_EARLY : LAT_EX_LATE;
  endfunction

  function automatic logic need_live(input logic [1:0] code);
    return (code == NEED_EARLY) || (code == NEED_LATE);
  endfunction

endpackage

// File: rtl/ilk_history.sv
// Age-indexed record of recently issued destinations. Entry g holds the
// producer issued g+1 cycles ago; entries older than LAT_MAX-1 cannot stall.
module ilk_history
  import opnd_interlock_pkg::*;
#(
  parameter int RW   = 5,
  parameter int NSRC = 3,
  parameter int SCW  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                wr_en,
  input  logic [RW-1:0]       wr_reg,
  input  logic                wr_load,
  input  logic [NSRC*RW-1:0]  src_reg,
  input  logic [2*NSRC-1:0]   src_need,
  output logic [SCW-1:0]      rem_max
);

  localparam int DEPTH = LAT_MAX - 1;

  logic            ent_v   [DEPTH];
  logic [RW-1:0]   ent_reg [DEPTH];
  logic            ent_ld  [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) begin
        ent_v[a]   <= 1'b0;
        ent_reg[a] <= '0;
        ent_ld[a]  <= 1'b0;
      end
    end else if (flush) begin
      for (int a = 0; a < DEPTH; a++) ent_v[a] <= 1'b0;
    end else begin
      ent_v[0]   <= wr_en && (wr_reg != '0);
      ent_reg[0] <= wr_reg;
      ent_ld[0]  <= wr_load;
      for (int a = 1; a < DEPTH; a++) begin
        ent_v[a]   <= ent_v[a-1];
        ent_reg[a] <= ent_reg[a-1];
        ent_ld[a]  <= ent_ld[a-1];
      end
    end
  end

  int src_rem [NSRC];

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [RW-1:0] rg;
    logic [1:0]    nd;
    assign rg = src_reg[RW*s +: RW];
    assign nd = src_need[2*s +: 2];

    always_comb begin
      int best;
      int r;
      best = 0;
      r    = 0;
      if (need_live(nd) && rg != '0) begin
        for (int a = 0; a < DEPTH; a++) begin
          if (ent_v[a] && ent_reg[a] == rg) begin
            r = req_lat(ent_ld[a], nd == NEED_EARLY) - (a + 1);
            if (r > best) best = r;
          end
        end
      end
      src_rem[s] = best;
    end
  end

  always_comb begin
    int best;
    best = 0;
    for (int s = 0; s < NSRC; s++)
      if (src_rem[s] > best) best = src_rem[s];
    rem_max = SCW'(best);
  end

endmodule

// File: rtl/ilk_lmw_seq.sv
// Issues the later words of a load-multiple one per cycle and reports the
// wait a consumer would see from the words not yet issued.
module ilk_lmw_seq
  import opnd_interlock_pkg::*;
#(
  parameter int RW      = 5,
  parameter int NSRC    = 3,
  parameter int MAX_LMW = 12,
  parameter int CW      = 4,
  parameter int SCW     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                start,
  input  logic [CW-1:0]       start_words,
  input  logic [RW-1:0]       start_reg,
  input  logic [NSRC*RW-1:0]  src_reg,
  input  logic [2*NSRC-1:0]   src_need,
  output logic                busy,
  output logic [RW-1:0]       wr_reg,
  output logic [SCW-1:0]      rem_max
);

  localparam int PEND_MAX = (MAX_LMW > 1) ? MAX_LMW - 1 : 1;

  logic [CW-1:0] left_q;
  logic [RW-1:0] next_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      next_q <= '0;
    end else if (flush) begin
      left_q <= '0;
    end else if (start) begin
      left_q <= start_words - 1'b1;
      next_q <= start_reg + 1'b1;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
      next_q <= next_q + 1'b1;
    end
  end

  assign busy   = (left_q != '0);
  assign wr_reg = next_q;

  int src_rem [NSRC];

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [RW-1:0] rg;
    logic [1:0]    nd;
    assign rg = src_reg[RW*s +: RW];
    assign nd = src_need[2*s +: 2];

    always_comb begin
      int best;
      int r;
      best = 0;
      r    = 0;
      if (busy && need_live(nd) && rg != '0) begin
        for (int j = 0; j < PEND_MAX; j++) begin
          if (j < int'(left_q) && (next_q + RW'(j)) == rg) begin
            r = j + req_lat(1'b1, nd == NEED_EARLY);
            if (r > best) best = r;
          end
        end
      end
      src_rem[s] = best;
    end
  end

  always_comb begin
    int best;
    best = int'(left_q);
    for (int s = 0; s < NSRC; s++)
      if (src_rem[s] > best) best = src_rem[s];
    rem_max = SCW'(best);
  end

  AST_SEQ_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start) else $error("load-multiple restarted while busy"); // R9

endmodule

// File: rtl/opnd_interlock.sv
module opnd_interlock
  import opnd_interlock_pkg::*;
#(
  parameter  int RW      = 5,
  parameter  int NSRC    = 3,
  parameter  int MAX_LMW = 12,
  localparam int CW      = $clog2(MAX_LMW + 1),
  localparam int SCW     = $clog2(MAX_LMW + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                iss_valid,
  output logic                iss_ready,
  input  logic [NSRC*RW-1:0]  src_reg,
  input  logic [2*NSRC-1:0]   src_need,
  input  logic [RW-1:0]       dst_reg,
  input  logic [1:0]          dst_kind,
  input  logic [CW-1:0]       lmw_words,
  output logic                stall,
  output logic [SCW-1:0]      stall_cycles
);

  logic            fire;
  logic [CW-1:0]   words_eff;
  logic            seq_start;
  logic            seq_busy;
  logic [RW-1:0]   seq_reg;
  logic [SCW-1:0]  seq_rem;
  logic [SCW-1:0]  hist_rem;
  logic            wr_en;
  logic [RW-1:0]   wr_reg;
  logic            wr_load;
  prod_kind_e      kind;

  assign kind      = prod_kind_e'(dst_kind);
  assign fire      = iss_valid && iss_ready;
  assign words_eff = (lmw_words == '0) ? CW'(1) : lmw_words;
  assign seq_start = fire && (kind == PK_LMULTI) && (words_eff > CW'(1));

  always_comb begin
    wr_en   = 1'b0;
    wr_reg  = dst_reg;
    wr_load = 1'b1;
    if (!flush) begin
      if (fire && kind != PK_NONE) begin
        wr_en   = 1'b1;
        wr_reg  = dst_reg;
        wr_load = (kind != PK_EXEC);
      end else if (seq_busy) begin
        wr_en   = 1'b1;
        wr_reg  = seq_reg;
        wr_load = 1'b1;
      end
    end
  end

  ilk_history #(.RW(RW), .NSRC(NSRC), .SCW(SCW)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .wr_en    (wr_en),
    .wr_reg   (wr_reg),
    .wr_load  (wr_load),
    .src_reg  (src_reg),
    .src_need (src_need),
    .rem_max  (hist_rem)
  );

  ilk_lmw_seq #(.RW(RW), .NSRC(NSRC), .MAX_LMW(MAX_LMW), .CW(CW), .SCW(SCW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .start       (seq_start),
    .start_words (words_eff),
    .start_reg   (dst_reg),
    .src_reg     (src_reg),
    .src_need    (src_need),
    .busy        (seq_busy),
    .wr_reg      (seq_reg),
    .rem_max     (seq_rem)
  );

  assign stall_cycles = (hist_rem > seq_rem) ? hist_rem : seq_rem;
  assign iss_ready    = !flush && (stall_cycles == '0);
  assign stall        = iss_valid && (stall_cycles != '0);

  // any operand that could match a record
  logic src_live;
  always_comb begin
    src_live = 1'b0;
    for (int s = 0; s < NSRC; s++)
      if (need_live(src_need[2*s +: 2]) && src_reg[RW*s +: RW] != '0) src_live = 1'b1;
  end

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> stall_cycles == '0) else $error("records survived flush"); // R10

  AST_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_cycles != '0 && !flush) |=>
      (flush || !$stable(src_reg) || !$stable(src_need) ||
       stall_cycles == SCW'($past(stall_cycles) - 1'b1)))
    else $error("stall count did not fall by one"); // R4

  AST_DEAD_SRC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_live && !seq_busy) |-> stall_cycles == '0)
    else $error("stall without a live operand"); // R6

  AST_LMW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && kind == PK_LMULTI && lmw_words > CW'(1)) |=> !iss_ready)
    else $error("issue reopened during load-multiple"); // R9

endmodule

// File: tb/opnd_interlock_test.sv
`timescale 1ns/1ps
module opnd_interlock_test;

  localparam int RW = 5, NSRC = 3, MAX_LMW = 12;
  localparam int CW = $clog2(MAX_LMW + 1), SCW = $clog2(MAX_LMW + 2);

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, iss_valid = 1'b0;
  logic iss_ready, stall;
  logic [NSRC*RW-1:0] src_reg = '0;
  logic [2*NSRC-1:0]  src_need = '0;
  logic [RW-1:0]      dst_reg = '0;
  logic [1:0]         dst_kind = 2'b00;
  logic [CW-1:0]      lmw_words = '0;
  logic [SCW-1:0]     stall_cycles;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  opnd_interlock #(.RW(RW), .NSRC(NSRC), .MAX_LMW(MAX_LMW)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .iss_valid(iss_valid),
    .iss_ready(iss_ready), .src_reg(src_reg), .src_need(src_need),
    .dst_reg(dst_reg), .dst_kind(dst_kind), .lmw_words(lmw_words),
    .stall(stall), .stall_cycles(stall_cycles));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual %0d expected <150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic present_prod(input int kind, input int dst, input int words);
    iss_valid = 1'b1; dst_kind = kind[1:0]; dst_reg = dst[RW-1:0];
    lmw_words = words[CW-1:0]; src_need = '0; src_reg = '0;
  endtask

  task automatic present_cons(input int r0, input int n0, input int r1, input int n1);
    iss_valid = 1'b1; dst_kind = 2'b00; dst_reg = '0; lmw_words = '0;
    src_reg  = {5'd0, r1[RW-1:0], r0[RW-1:0]};
    src_need = {2'b00, n1[1:0], n0[1:0]};
  endtask

  task automatic drain();
    @(negedge clk);
    iss_valid = 1'b0; src_need = '0; flush = 1'b0;
    repeat (16) @(negedge clk);
  endtask

  // producer, gap idle cycles, consumer on one operand; measure wait
  task automatic run_case(input string req, input int kind, input int dst, input int words,
                          input int creg, input int need, input int gap, input int exp);
    int cnt;
    @(negedge clk);
    present_prod(kind, dst, words);
    @(negedge clk);
    if (gap > 0) begin
      iss_valid = 1'b0;
      repeat (gap) @(negedge clk);
    end
    present_cons(creg, need, 0, 0);
    #1;
    check({req, " count"}, int'(stall_cycles), exp);
    check({req, " stall"}, int'(stall), int'(exp != 0));
    cnt = 0;
    while (!iss_ready && cnt < 40) begin
      @(negedge clk); #1; cnt++;
    end
    check({req, " wait"}, cnt, exp);
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset ready", int'(iss_ready), 1);
    check("R1 reset count", int'(stall_cycles), 0);
    check("R1 reset stall", int'(stall), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R5: kinds x need codes x gaps
    for (int k = 1; k <= 2; k++)
      for (int n = 0; n <= 3; n++)
        for (int g = 0; g <= 3; g++) begin
          int lat, e;
          lat = (k == 2) ? ((n == 1) ? 3 : 2) : ((n == 1) ? 2 : 1);
          e = (n == 1 || n == 2) ? imax(0, lat - 1 - g) : 0;
          run_case((k == 2) ? "R3 load" : "R2 exec", k, 7, 1, 7, n, g, e);
        end

    // R6: register 0 and no-destination producers
    run_case("R6 zero reg", 2, 0, 1, 0, 1, 0, 0);
    run_case("R6 no dest", 0, 4, 1, 4, 1, 0, 0);
    run_case("R5 unrelated reg", 2, 4, 1, 5, 1, 0, 0);

    // R8 R9: load-multiple sweep
    for (int nw = 1; nw <= 5; nw++)
      for (int m = 1; m <= nw; m++)
        for (int n = 1; n <= 2; n++)
          for (int g = 0; g <= 2; g++) begin
            int lat, e;
            lat = (n == 1) ? 3 : 2;
            e = imax(0, imax(nw - 1 - g, m + lat - 2 - g));
            run_case("R8 lmw word", 3, 20, nw, 20 + m - 1, n, g, e);
          end
    run_case("R9 lmw zero words", 3, 20, 0, 20, 1, 0, 2);
    run_case("R9 lmw zero words next", 3, 20, 0, 21, 1, 0, 0);
    run_case("R8 lmw wrap", 3, 31, 3, 1, 1, 0, 4);
    run_case("R9 lmw long", 3, 8, 12, 2, 1, 0, 11);

    // R7: two producers, two operands
    @(negedge clk); present_prod(2, 5, 1);
    @(negedge clk); present_prod(2, 6, 1);
    @(negedge clk); present_cons(5, 1, 6, 1);
    #1; check("R7 max of producers", int'(stall_cycles), 2);
    present_cons(6, 2, 5, 1);
    #1; check("R7 max of operands", int'(stall_cycles), 1);
    drain();

    // R10: flush clears a load record
    @(negedge clk); present_prod(2, 9, 1);
    @(negedge clk); flush = 1'b1; present_cons(9, 1, 0, 0);
    #1; check("R10 ready low in flush", int'(iss_ready), 0);
    @(negedge clk); flush = 1'b0;
    #1; check("R10 record cleared", int'(stall_cycles), 0);
    drain();

    // R10: flush aborts a load-multiple
    @(negedge clk); present_prod(3, 10, 4);
    @(negedge clk); flush = 1'b1; iss_valid = 1'b0;
    @(negedge clk); flush = 1'b0; present_cons(13, 1, 10, 1);
    #1; check("R10 lmw aborted count", int'(stall_cycles), 0);
    check("R10 lmw aborted ready", int'(iss_ready), 1);
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule